// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block sequences a non-pipelined 16-bit processor whose memory port is one byte wide. Each instruction is fetched in two cycles, low byte first and then high byte. Execution begins in the high-byte cycle. Most instruction classes also retire in that cycle. Memory accesses add one or two cycles, and multiply/divide operations hold the sequencer until the arithmetic unit reports completion. A one-hot step vector records the sequencer's position and is brought out as an output, together with per-step strobes.

The decoder supplies a class code for the fetched instruction. The sequencer samples that code during the high-byte cycle and keeps it for any extra cycles. The block also keeps the program counter. The counter moves to the next instruction when the fetch completes, unless a taken jump supplies a new address in the finishing cycle. A register write enable is raised in the finishing cycle, so the result is visible from the following step onward.

Top module: `instr_sequencer`

## Requirements
- R1: After reset the step vector is 5'b00001 (low-byte fetch), the program counter is 0x0000, and `exec_finish` and `reg_we` are low while `wb_req` is low.
- R2: Exactly one bit of `step_vec` is high in every cycle. Bit 0 is the low-byte fetch, bit 1 the high-byte fetch, bit 2 the first memory cycle, bit 3 the second memory cycle and bit 4 the multiply/divide wait.
- R3: The step after the low-byte fetch is always the high-byte fetch. `step_lo` mirrors bit 0. `step_hi`, `exec_start` and `pc_inc` are all high in the high-byte cycle.
- R4: Classes 0 (ALU), 1 (jump) and the unused codes 5 to 7 finish in the high-byte cycle, so the instruction lasts 2 cycles and the next cycle is a low-byte fetch.
- R5: Class 2 (byte load/store) takes one extra cycle and lasts 3 cycles in total. Class 3 (word load/store) takes two extra cycles and lasts 4 cycles.
- R6: Class 4 (multiply/divide) enters the wait step after the high-byte cycle and finishes in the first wait cycle in which `md_done` is high. `md_done` has no effect in any other step.
- R7: When a fetch completes at the end of the high-byte cycle, the program counter advances by 2 modulo 2^16.
- R8: A high `jmp_take` in the finishing cycle loads `jmp_addr` into the program counter in place of the increment. `jmp_take` has no effect in any other cycle.
- R9: `reg_we` is high exactly in the finishing cycle of an instruction whose `wb_req` is high.
- R10: The class code is sampled only in the high-byte cycle. Changes to `instr_cls` during the extra cycles do not change the instruction's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_cls | input | 3 | Decoded class of the fetched instruction |
| wb_req | input | 1 | The instruction writes a register |
| md_done | input | 1 | Multiply/divide unit has finished |
| jmp_take | input | 1 | Take a jump at finish |
| jmp_addr | input | 16 | Jump target address |
| step_vec | output | 5 | One-hot step register |
| step_lo | output | 1 | Low-byte fetch strobe |
| step_hi | output | 1 | High-byte fetch strobe |
| exec_start | output | 1 | Execution begins this cycle |
| exec_finish | output | 1 | Instruction finishes this cycle |
| pc_inc | output | 1 | Program counter advances at this edge |
| reg_we | output | 1 | Register write enable |
| pc | output | 16 | Program counter |

## Verification
The assertions assume that `instr_cls` is valid during the high-byte cycle. They also assume that the multiply/divide unit eventually raises `md_done` while the sequencer waits. The stimulus holds a legal class through the high-byte cycle and raises `md_done` after a bounded random latency of 1 to 6 wait cycles. In noisy runs it deliberately raises `md_done` and `jmp_take` in steps where they must be ignored, and it scrambles the class code after the high-byte cycle.

// File: rtl/isq_pkg.sv
package isq_pkg;

  typedef enum logic [2:0] {
    CLS_ALU    = 3'd0,
    CLS_JUMP   = 3'd1,
    CLS_MEM_B  = 3'd2,
    CLS_MEM_W  = 3'd3,
    CLS_MULDIV = 3'd4
  } isq_cls_e;

  localparam int ST_LO  = 0;
  localparam int ST_HI  = 1;
  localparam int ST_M1  = 2;
  localparam int ST_M2  = 3;
  localparam int ST_MD  = 4;
  localparam int NSTEP  = 5;

  // number of memory cycles added after the fetch for a class code
  function automatic int unsigned mem_extra(input logic [2:0] cls);
    case (cls)
      CLS_MEM_B: mem_extra = 1;
      CLS_MEM_W: mem_extra = 2;
      default:   mem_extra = 0;
    endcase
  endfunction

  // sequential fetch address with wrap-around at the counter width
  function automatic logic [15:0] fetch_next(input logic [15:0] cur,
                                             input logic [15:0] step);
    fetch_next = cur + step;
  endfunction

endpackage

// File: rtl/isq_step.sv
module isq_step
  import isq_pkg::*;
#(
  parameter int CLS_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CLS_W-1:0]   cls_in,
  input  logic               md_done,
  output logic [NSTEP-1:0]   step_q,
  output logic               finish
);

  logic [CLS_W-1:0] cls_q;
  logic [CLS_W-1:0] eff_cls;
  logic [NSTEP-1:0] step_nxt;
  int unsigned      extra;

  // class is decoded live in the high-byte cycle, held afterwards
  assign eff_cls = step_q[ST_HI] ? cls_in : cls_q;
  assign extra   = mem_extra(eff_cls);

  always_comb begin
    step_nxt = '0;
    unique case (1'b1)
      step_q[ST_LO]: step_nxt[ST_HI] = 1'b1;
      step_q[ST_HI]: begin
        if (extra != 0)                       step_nxt[ST_M1] = 1'b1;
        else if (eff_cls == CLS_MULDIV)       step_nxt[ST_MD] = 1'b1;
        else                                  step_nxt[ST_LO] = 1'b1;
      end
      step_q[ST_M1]: begin
        if (extra > 1) step_nxt[ST_M2] = 1'b1;
        else           step_nxt[ST_LO] = 1'b1;
      end
      step_q[ST_M2]: step_nxt[ST_LO] = 1'b1;
      step_q[ST_MD]: begin
        if (md_done) step_nxt[ST_LO] = 1'b1;
        else         step_nxt[ST_MD] = 1'b1;
      end
      default: step_nxt[ST_LO] = 1'b1;
    endcase
  end

  assign finish = step_nxt[ST_LO] && !step_q[ST_LO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= NSTEP'(1) << ST_LO;
      cls_q  <= '0;
    end else begin
      step_q <= step_nxt;
      if (step_q[ST_HI]) cls_q <= cls_in;
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(step_q) == 1);

  a_r3_lo_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
    step_q[ST_LO] |=> step_q[ST_HI]);

  a_r4_finish_to_lo: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> step_q[ST_LO]);

  a_r6_md_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q[ST_MD] && !md_done) |=> step_q[ST_MD]);

  a_r5_m2_after_m1: assert property (@(posedge clk) disable iff (!rst_n)
    step_q[ST_M2] |-> $past(step_q[ST_M1]));

endmodule

// File: rtl/isq_pc.sv
module isq_pc
  import isq_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int INSTR_BYTES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch_done,
  input  logic            finish,
  input  logic            jmp_take,
  input  logic [PC_W-1:0] jmp_addr,
  output logic [PC_W-1:0] pc_q
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(INSTR_BYTES);

  logic jmp_load;
  assign jmp_load = finish && jmp_take;

  always_ff @(posedge clk) begin
    if (!rst_n)          pc_q <= '0;
    else if (jmp_load)   pc_q <= jmp_addr;
    else if (fetch_done) pc_q <= fetch_next(pc_q, PC_STEP);
  end

  a_r7_pc_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done && !jmp_load) |=> pc_q == PC_W'($past(pc_q) + PC_STEP));

  a_r8_jump_load: assert property (@(posedge clk) disable iff (!rst_n)
    jmp_load |=> pc_q == $past(jmp_addr));

  a_r8_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_done && !jmp_load) |=> $stable(pc_q));

endmodule

// File: rtl/isq_strobe.sv
module isq_strobe
  import isq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSTEP-1:0] step_q,
  input  logic             finish,
  input  logic             wb_req,
  output logic             step_lo,
  output logic             step_hi,
  output logic             exec_start,
  output logic             pc_inc,
  output logic             reg_we
);

  assign step_lo    = step_q[ST_LO];
  assign step_hi    = step_q[ST_HI];
  assign exec_start = step_q[ST_HI];
  assign pc_inc     = step_q[ST_HI];
  assign reg_we     = finish && wb_req;

  a_r9_we_only_at_finish: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !step_q[ST_LO]);

endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
  import isq_pkg::*;
#(
  parameter int PC_W        = 16,
  parameter int CLS_W       = 3,
  parameter int INSTR_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CLS_W-1:0]  instr_cls,
  input  logic              wb_req,
  input  logic              md_done,
  input  logic              jmp_take,
  input  logic [PC_W-1:0]   jmp_addr,
  output logic [NSTEP-1:0]  step_vec,
  output logic              step_lo,
  output logic              step_hi,
  output logic              exec_start,
  output logic              exec_finish,
  output logic              pc_inc,
  output logic              reg_we,
  output logic [PC_W-1:0]   pc
);

  logic             finish_w;
  logic [NSTEP-1:0] step_w;
  logic             pc_inc_w;

  isq_step #(.CLS_W(CLS_W)) u_step (
    .clk     (clk),
    .rst_n   (rst_n),
    .cls_in  (instr_cls),
    .md_done (md_done),
    .step_q  (step_w),
    .finish  (finish_w)
  );

  isq_strobe u_strobe (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_q     (step_w),
    .finish     (finish_w),
    .wb_req     (wb_req),
    .step_lo    (step_lo),
    .step_hi    (step_hi),
    .exec_start (exec_start),
    .pc_inc     (pc_inc_w),
    .reg_we     (reg_we)
  );

  isq_pc #(.PC_W(PC_W), .INSTR_BYTES(INSTR_BYTES)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetch_done (pc_inc_w),
    .finish     (finish_w),
    .jmp_take   (jmp_take),
    .jmp_addr   (jmp_addr),
    .pc_q       (pc)
  );

  assign step_vec    = step_w;
  assign exec_finish = finish_w;
  assign pc_inc      = pc_inc_w;

endmodule

// File: tb/instr_sequencer_test.sv
module instr_sequencer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  instr_cls = '0;
  logic        wb_req = 1'b0;
  logic        md_done = 1'b0;
  logic        jmp_take = 1'b0;
  logic [15:0] jmp_addr = '0;
  logic [4:0]  step_vec;
  logic        step_lo, step_hi, exec_start, exec_finish, pc_inc, reg_we;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  instr_sequencer uut (
    .clk(clk), .rst_n(rst_n), .instr_cls(instr_cls), .wb_req(wb_req),
    .md_done(md_done), .jmp_take(jmp_take), .jmp_addr(jmp_addr),
    .step_vec(step_vec), .step_lo(step_lo), .step_hi(step_hi),
    .exec_start(exec_start), .exec_finish(exec_finish), .pc_inc(pc_inc),
    .reg_we(reg_we), .pc(pc)
  );

  function automatic int bench_len(input logic [2:0] c, input int lat);
    if (c == 3'd2) return 3;
    if (c == 3'd3) return 4;
    if (c == 3'd4) return 2 + lat;
    return 2;
  endfunction

  function automatic logic [15:0] bench_pc(input logic [15:0] p0, input bit jt,
                                           input logic [15:0] ja);
    return jt ? ja : 16'(p0 + 16'd2);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // entered just after a negedge with the sequencer in the low-byte step
  task automatic run_instr(input logic [2:0] c, input bit wb, input bit jt,
                           input logic [15:0] ja, input int lat, input bit noise);
    int cyc = 0;
    int mdc = 0;
    bit done = 0;
    logic [15:0] p0 = pc;
    chk(step_vec == 5'b00001, "R3 start at low fetch", int'(step_vec), 1);
    while (!done) begin
      cyc++;
      instr_cls = (noise && cyc > 2) ? 3'($urandom_range(0, 7)) : c;
      wb_req    = wb;
      jmp_addr  = ja;
      if (step_vec[4]) begin
        mdc++;
        md_done = (mdc == lat);
      end else begin
        md_done = noise;
      end
      jmp_take = noise;
      #1;
      chk($countones(step_vec) == 1, "R2 one-hot", int'(step_vec), 1);
      if (cyc == 1) chk(step_lo && !step_hi, "R3 low strobe", int'(step_vec), 1);
      if (cyc == 2) chk(step_hi && exec_start && pc_inc, "R3 high strobes",
                        int'({step_hi, exec_start, pc_inc}), 7);
      if (exec_finish) begin
        jmp_take = jt;
        done = 1;
      end
      #0;
      chk(reg_we == (exec_finish && wb), "R9 write enable", int'(reg_we),
          int'(exec_finish && wb));
      if (cyc > 64) done = 1;
      @(negedge clk);
    end
    md_done = 0; jmp_take = 0;
    #1;
    if (c == 3'd4)
      chk(cyc == bench_len(c, lat), "R6 muldiv length", cyc, bench_len(c, lat));
    else if (c == 3'd2 || c == 3'd3)
      chk(cyc == bench_len(c, lat), noise ? "R10 memory length under class change" :
          "R5 memory length", cyc, bench_len(c, lat));
    else
      chk(cyc == bench_len(c, lat), "R4 short length", cyc, bench_len(c, lat));
    chk(pc == bench_pc(p0, jt, ja), jt ? "R8 jump target" : "R7 pc plus two",
        int'(pc), int'(bench_pc(p0, jt, ja)));
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(step_vec == 5'b00001, "R1 reset step", int'(step_vec), 1);
    chk(pc == 16'h0000, "R1 reset pc", int'(pc), 0);
    chk(!exec_finish && !reg_we, "R1 reset strobes", int'({exec_finish, reg_we}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // directed: each class once
    run_instr(3'd0, 1, 0, 16'h0, 1, 0);
    run_instr(3'd1, 0, 1, 16'h1234, 1, 0);
    run_instr(3'd2, 1, 0, 16'h0, 1, 0);
    run_instr(3'd3, 1, 0, 16'h0, 1, 0);
    run_instr(3'd4, 1, 0, 16'h0, 1, 0);
    run_instr(3'd4, 0, 0, 16'h0, 5, 0);
    run_instr(3'd6, 0, 0, 16'h0, 1, 0);
    // R7 wrap: jump near the top then fetch across it
    run_instr(3'd1, 0, 1, 16'hFFFE, 1, 0);
    run_instr(3'd0, 0, 0, 16'h0, 1, 0);
    chk(pc == 16'h0000, "R7 wrap to zero", int'(pc), 0);
    // R6/R8/R10: ignored inputs asserted off their step
    run_instr(3'd3, 0, 0, 16'hBEEF, 1, 1);
    run_instr(3'd2, 1, 0, 16'hBEEF, 1, 1);
    run_instr(3'd4, 1, 1, 16'h4400, 3, 1);
    // constrained random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] c = 3'($urandom_range(0, 7));
      run_instr(c, 1'($urandom), 1'($urandom_range(0, 3) == 0),
                16'($urandom) & 16'hFFFE, int'($urandom_range(1, 6)),
                1'($urandom));
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule